// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines a shift register that holds the outcomes of the most recent resolved branches with a table of 2-bit saturating counters. The table is two-dimensional. The low bits of the branch address pick a row, and the current history value picks one counter inside that row. Each row also carries an address tag, so a prediction is only offered for a branch that owns the row. Any other lookup reports a miss and falls back to not-taken.

The fetch side presents an address on the lookup port and receives a registered hit flag and direction one cycle later. The execute side reports each resolved branch on the update port. That update trains the selected counter, or claims the row if the tag does not match, and then shifts the outcome into the history.

Top module: `corr_branch_predictor`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `lk_valid` high, and low after a cycle with `lk_valid` low. `rsp_hit`/`rsp_taken` belong to that lookup.
- R2: Address bits [5:0] select one of 64 rows and bits [17:6] form the 12-bit tag. A lookup hits only when the row is valid and its stored tag equals the lookup tag.
- R3: Within a row, the counter used by both lookup and update is the one whose column number equals the 4-bit history value at that moment.
- R4: A lookup that misses returns `rsp_hit`=0 and `rsp_taken`=0.
- R5: A lookup that hits returns `rsp_taken`=1 exactly when the selected counter holds 2 or 3.
- R6: An update that hits raises the selected counter by one on taken and lowers it by one on not-taken, saturating at 3 and 0. Other counters are untouched.
- R7: An update that misses writes the new tag, marks the row valid and sets every counter of the row to 1. It then trains the selected counter as in R6, leaving it at 2 if taken or 0 if not taken.
- R8: Every update shifts the history left by one and places the outcome (taken=1) in bit 0. Lookups never change the history.
- R9: Synchronous active-high reset invalidates every row, clears the history to 0 and drops `rsp_valid`.
- R10: A lookup in the same cycle as an update sees the table and history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 18 | Branch address to predict |
| up_valid | input | 1 | Resolved-branch update |
| up_addr | input | 18 | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Tag matched a valid row |
| rsp_taken | output | 1 | Predicted direction |

## Verification
A lookup response appears one clock after the request. An update changes the table and history at the same edge, so it first affects a lookup issued in the following cycle. The bench drives inputs on falling edges. At the next falling edge it compares the response with a value its reference model computed when the request was driven, before the model applied that cycle's update. This keeps the check in line with both latencies and with the same-cycle ordering rule.

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int ROWS   = 64,
  parameter int HIST_W = 4,
  parameter int TAG_W  = 12,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int COLS   = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_taken
);

  logic [ROWS-1:0]  row_vld;
  logic [TAG_W-1:0] row_tag [ROWS];
  logic [1:0]       ctr     [ROWS][COLS];
  logic [HIST_W-1:0] hist;

  wire [IDX_W-1:0] lk_idx = lk_addr[IDX_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] up_idx = up_addr[IDX_W-1:0];
  wire [TAG_W-1:0] up_tag = up_addr[ADDR_W-1:IDX_W];

  wire       lk_hit = row_vld[lk_idx] && (row_tag[lk_idx] == lk_tag);
  wire       up_hit = row_vld[up_idx] && (row_tag[up_idx] == up_tag);
  wire [1:0] lk_ctr = ctr[lk_idx][hist];
  wire [1:0] up_ctr = ctr[up_idx][hist];

  wire [1:0] up_next = up_taken ? ((up_ctr == 2'd3) ? 2'd3 : up_ctr + 2'd1)
                                : ((up_ctr == 2'd0) ? 2'd0 : up_ctr - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_vld   <= '0;
      hist      <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_taken <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_taken <= lk_valid && lk_hit && lk_ctr[1];
      if (up_valid) begin
        hist <= {hist[HIST_W-2:0], up_taken};
        if (!up_hit) row_vld[up_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && up_valid) begin
      if (up_hit) begin
        ctr[up_idx][hist] <= up_next;
      end else begin
        row_tag[up_idx] <= up_tag;
        for (int c = 0; c < COLS; c++)
          ctr[up_idx][c] <= (c == int'(hist)) ? (up_taken ? 2'd2 : 2'd0) : 2'd1;
      end
    end
  end

endmodule

module corr_branch_predictor_chk #(
  parameter int HIST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              lk_valid,
  input logic              up_valid,
  input logic              up_taken,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_taken,
  input logic [HIST_W-1:0] hist
);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  a_r4_miss_not_taken: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> !rsp_taken);

  a_r8_hist_shift: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (hist[0] == $past(up_taken)) &&
                 (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

  a_r8_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(hist));

  a_r9_reset_state: assert property (@(posedge clk)
    rst |=> (!rsp_valid && hist == '0));

endmodule

bind corr_branch_predictor corr_branch_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .up_valid(up_valid),
  .up_taken(up_taken), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_taken(rsp_taken), .hist(hist)
);

// File: tb/tb_corr_branch_predictor.sv
module tb_corr_branch_predictor;
  localparam int ROWS = 64, COLS = 16;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, up_valid = 0, up_taken = 0;
  logic [17:0] lk_addr = '0, up_addr = '0;
  logic rsp_valid, rsp_hit, rsp_taken;

  always #5 clk = ~clk;

  corr_branch_predictor dut (.*);

  int checks = 0, fails = 0;

  bit        m_vld [ROWS];
  bit [11:0] m_tag [ROWS];
  bit [1:0]  m_ctr [ROWS][COLS];
  bit [3:0]  m_hist;

  bit pend = 0, e_vld = 0, e_hit = 0, e_tk = 0;
  string pend_tag = "";

  function automatic bit m_hit(bit [17:0] a);
    return m_vld[a[5:0]] && m_tag[a[5:0]] == a[17:6];
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic m_update(bit [17:0] a, bit t);
    bit [5:0] i = a[5:0];
    if (m_hit(a)) begin
      if (t && m_ctr[i][m_hist] != 3) m_ctr[i][m_hist]++;
      if (!t && m_ctr[i][m_hist] != 0) m_ctr[i][m_hist]--;
    end else begin
      m_vld[i] = 1; m_tag[i] = a[17:6];
      for (int c = 0; c < COLS; c++) m_ctr[i][c] = 2'd1;
      m_ctr[i][m_hist] = t ? 2'd2 : 2'd0;
    end
    m_hist = {m_hist[2:0], t};
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8 R10: one cycle of stimulus, response checked one cycle later
  task automatic step(bit lv, bit [17:0] la, bit uv, bit [17:0] ua, bit ut, string tag);
    @(negedge clk);
    if (pend) begin
      check({"R1 rsp_valid ", pend_tag}, rsp_valid, e_vld);
      if (e_vld) begin
        check({"R2/R4 hit ", pend_tag}, rsp_hit, e_hit);
        check({"R3/R5 taken ", pend_tag}, rsp_taken, e_tk);
      end
    end
    lk_valid = lv; lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut;
    pend = 1; pend_tag = tag; e_vld = lv;
    e_hit = m_hit(la);
    e_tk  = e_hit && m_ctr[la[5:0]][m_hist][1];
    if (uv) m_update(ua, ut);
  endtask

  function automatic bit [17:0] pick();
    bit [5:0] r = 6'($urandom_range(0, 5));
    bit [11:0] t = 12'($urandom_range(0, 2) * 12'h155 + 12'h0a);
    return {t, r};
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    m_hist = '0;
    for (int r = 0; r < ROWS; r++) m_vld[r] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 rsp_valid after reset", rsp_valid, 1'b0);

    step(1, 18'h0_0040, 0, 0, 0, "R9 cold miss");
    step(0, 0, 1, 18'h0_0040, 1, "R7 allocate taken");
    step(1, 18'h0_0040, 0, 0, 0, "R3 new column after shift");
    // R10: lookup and update together
    step(1, 18'h0_0040, 1, 18'h0_0040, 1, "R10 same-cycle");
    step(1, 18'h0_0040, 0, 0, 0, "R10 after");
    // R2: alias same row, different tag
    step(1, 18'h0_0080, 1, 18'h0_0080, 0, "R2 alias lookup");
    step(1, 18'h0_0040, 0, 0, 0, "R2 evicted");
    // R6: saturation, history pinned by repeated taken
    for (int k = 0; k < 10; k++) step(1, 18'h0_0103, 1, 18'h0_0103, 1, "R6 sat up");
    for (int k = 0; k < 10; k++) step(1, 18'h0_0103, 1, 18'h0_0103, 0, "R6 sat down");
    step(0, 0, 0, 0, 0, "R1 idle");
    // R8: lookups alone leave history unchanged
    for (int k = 0; k < 4; k++) step(1, 18'h0_0103, 0, 0, 0, "R8 lookup only");

    for (int k = 0; k < 3000; k++) begin
      bit lv = $urandom_range(0, 3) != 0;
      bit uv = $urandom_range(0, 2) != 0;
      step(lv, pick(), uv, pick(), 1'($urandom_range(0, 1)), "random");
    end
    step(0, 0, 0, 0, 0, "flush");
    step(0, 0, 0, 0, 0, "flush");

    // R9: reset mid-run clears rows and history
    @(negedge clk); rst = 1; lk_valid = 0; up_valid = 0; pend = 0;
    @(negedge clk); rst = 0;
    check("R9 rsp_valid low", rsp_valid, 1'b0);
    for (int r = 0; r < ROWS; r++) m_vld[r] = 0;
    m_hist = '0;
    step(1, 18'h0_0103, 0, 0, 0, "R9 rows invalid");
    step(0, 0, 0, 0, 0, "flush");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule